// File: doc/BRIEF.md
# S/PDIF Receive Sample Word Formatter

This block sits after the biphase decoder of an S/PDIF receiver. Each decoded subframe gives it an audio sample of up to 24 bits, a parity-error flag, the validity, user and channel-status bits, and a 2-bit preamble code. The block turns that subframe into the 32-bit word that goes into the receive data path. A 2-bit format input selects one of three layouts: sample at the bottom with status above it, sample at the top with status below it, or two 16-bit samples packed into one word.

Four mask inputs can force fields of the status area to zero. One mask covers parity, one covers validity, one covers the user and channel-status pair, and one covers the preamble code. In packed mode the word goes out only when its second sample arrives. A stereo-order input keeps each packed pair aligned on channel A, so that the lower half always holds a left sample.

Every result is registered, and a one-clock valid strobe marks it.

Top module: `spdif_word_fmt`

## Requirements
- R1: With format 00, the output word holds the sample in bits 23:0, the parity error in bit 24, V in bit 25, U in bit 26, C in bit 27, the preamble code in bits 29:28, and zeros in bits 31:30.
- R2: With format 01, the output word holds the parity error in bit 0, V in bit 1, U in bit 2, C in bit 3, the preamble code in bits 5:4, zeros in bits 7:6, and the sample in bits 31:8.
- R3: Format code 11 gives exactly the word that format 00 would give.
- R4: With format 10 (packed), the first accepted sample produces no output, and its bits 23:8 are held. The second sample produces the word {second[23:8], first[23:8]}. No status fields appear in this word.
- R5: When the parity mask is set, the parity-error field of formats 00, 01 and 11 reads zero.
- R6: When the validity mask is set, the V field reads zero.
- R7: When the channel-status/user mask is set, both the U field and the C field read zero.
- R8: When the preamble mask is set, the 2-bit preamble field reads zero.
- R9: The preamble codes are 01 for a block-start sample, 10 for a channel A sample and 11 for a channel B sample (code 00 counts as channel A). In packed mode with stereo order set, a channel B sample that arrives while no half is held is discarded. It produces no output and is not held.
- R10: In packed mode with stereo order set, a channel A or block-start sample that arrives while a half is held replaces that half. With stereo order clear, any sample that arrives while a half is held completes the pair.
- R11: While the format is not 10, any held half is dropped, so the next packed pair starts from a new first sample.
- R12: After reset, out_valid and out_word are 0. A word appears with out_valid high in the cycle after the subframe that completes it, and out_valid stays high for one cycle per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded subframe is present this cycle |
| in_sample | input | 24 | Audio sample |
| in_perr | input | 1 | Parity error flag of the subframe |
| in_v | input | 1 | Validity bit |
| in_u | input | 1 | User bit |
| in_c | input | 1 | Channel-status bit |
| in_pre | input | 2 | Preamble code: 01 block start, 10 channel A, 11 channel B |
| cfg_fmt | input | 2 | Layout: 00 low sample, 01 high sample, 10 packed, 11 same as 00 |
| cfg_mask_par | input | 1 | Zero the parity-error field |
| cfg_mask_val | input | 1 | Zero the validity field |
| cfg_mask_cu | input | 1 | Zero the user and channel-status fields |
| cfg_mask_pre | input | 1 | Zero the preamble field |
| cfg_chan_order | input | 1 | Keep packed pairs aligned on channel A |
| out_valid | output | 1 | One-cycle strobe for a new word |
| out_word | output | 32 | Formatted word |

## Verification
Two functions can meet on one subframe. The first is the stereo-order rule, which may discard or replace a half. The second is completion of a packed pair, which emits a word. The bench provokes this by sending a channel B sample with no half held, and by sending two channel A samples in a row, each followed by a channel B sample. It judges the result by the word that finally appears: that word must pair the last accepted channel A half with the channel B half, and out_valid must stay low on the subframes that were discarded or replaced. A format change between the two halves of a pair is also driven, to confirm that the held half is dropped.

// File: rtl/spdif_fmt_pkg.sv
package spdif_fmt_pkg;

   // layout select codes
   localparam logic [1:0] FMT_RIGHT = 2'b00;
   localparam logic [1:0] FMT_LEFT  = 2'b01;
   localparam logic [1:0] FMT_PACK  = 2'b10;
   localparam logic [1:0] FMT_RSVD  = 2'b11;

   // preamble codes
   localparam logic [1:0] PRE_BLK   = 2'b01;
   localparam logic [1:0] PRE_CHA   = 2'b10;
   localparam logic [1:0] PRE_CHB   = 2'b11;

   typedef struct packed {
      logic       perr;
      logic       v;
      logic       u;
      logic       c;
      logic [1:0] pre;
   } side_t;

   localparam int SIDE_W = $bits(side_t);

endpackage

// File: rtl/spdif_side_mask.sv
module spdif_side_mask
   import spdif_fmt_pkg::*;
(
   input  side_t side_in,
   input  logic  mask_par,
   input  logic  mask_val,
   input  logic  mask_cu,
   input  logic  mask_pre,
   output side_t side_out
);

   always_comb begin
      side_out      = side_in;
      side_out.perr = side_in.perr & ~mask_par;
      side_out.v    = side_in.v    & ~mask_val;
      side_out.u    = side_in.u    & ~mask_cu;
      side_out.c    = side_in.c    & ~mask_cu;
      side_out.pre  = side_in.pre  & {2{~mask_pre}};
   end

endmodule

// File: rtl/spdif_word_layout.sv
module spdif_word_layout
   import spdif_fmt_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int WORD_W   = 32
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  side_t               side,
   input  logic                left_sel,
   output logic [WORD_W-1:0]   word
);

   // status bits sit beside the sample; in left layout the sample is MSB aligned
   localparam int LEFT_LSB = WORD_W - SAMPLE_W;

   logic [WORD_W-1:0] right_w;
   logic [WORD_W-1:0] left_w;

   always_comb begin
      right_w                   = '0;
      right_w[SAMPLE_W-1:0]     = sample;
      right_w[SAMPLE_W]         = side.perr;
      right_w[SAMPLE_W+1]       = side.v;
      right_w[SAMPLE_W+2]       = side.u;
      right_w[SAMPLE_W+3]       = side.c;
      right_w[SAMPLE_W+5 -: 2]  = side.pre;
   end

   always_comb begin
      left_w                        = '0;
      left_w[0]                     = side.perr;
      left_w[1]                     = side.v;
      left_w[2]                     = side.u;
      left_w[3]                     = side.c;
      left_w[5:4]                   = side.pre;
      left_w[WORD_W-1:LEFT_LSB]     = sample;
   end

   assign word = left_sel ? left_w : right_w;

endmodule

// File: rtl/spdif_pair_packer.sv
module spdif_pair_packer
   import spdif_fmt_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int HALF_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pack_mode,
   input  logic                take,
   input  logic                chan_order,
   input  logic [1:0]          pre,
   input  logic [SAMPLE_W-1:0] sample,
   output logic                fire,
   output logic [2*HALF_W-1:0] pair_word
);

   logic [HALF_W-1:0] half;
   logic [HALF_W-1:0] hold_q;
   logic              held_q;
   logic              is_chb;
   logic              drop;
   logic              restart;

   generate
      if (HALF_W == SAMPLE_W) begin : g_full
         assign half = sample;
      end else begin : g_trunc
         assign half = sample[SAMPLE_W-1 -: HALF_W];
      end
   endgenerate

   assign is_chb  = (pre == PRE_CHB);
   assign drop    = chan_order &  is_chb & ~held_q;
   assign restart = chan_order & ~is_chb &  held_q;
   assign fire    = take & held_q & ~restart;
   assign pair_word = {half, hold_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         hold_q <= '0;
      end else if (!pack_mode) begin
         held_q <= 1'b0;
      end else if (take && !drop) begin
         if (!held_q || restart) begin
            hold_q <= half;
            held_q <= 1'b1;
         end else begin
            held_q <= 1'b0;
         end
      end
   end

   AST_PACK_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pack_mode && take && !held_q && !drop) |=> held_q)   // R4
      else $error("first packed half not held");

   AST_ORDER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (pack_mode && take && chan_order && is_chb && !held_q) |-> !fire ##1 !held_q)   // R9
      else $error("stray channel B sample was kept");

   AST_LEAVE_PACK: assert property (@(posedge clk) disable iff (!rst_n)
      !pack_mode |=> !held_q)   // R11
      else $error("half held outside packed mode");

endmodule

// File: rtl/spdif_word_fmt.sv
module spdif_word_fmt
   import spdif_fmt_pkg::*;
#(
   parameter int SAMPLE_W = 24,
   parameter int WORD_W   = 32,
   parameter int HALF_W   = WORD_W / 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_sample,
   input  logic                in_perr,
   input  logic                in_v,
   input  logic                in_u,
   input  logic                in_c,
   input  logic [1:0]          in_pre,
   input  logic [1:0]          cfg_fmt,
   input  logic                cfg_mask_par,
   input  logic                cfg_mask_val,
   input  logic                cfg_mask_cu,
   input  logic                cfg_mask_pre,
   input  logic                cfg_chan_order,
   output logic                out_valid,
   output logic [WORD_W-1:0]   out_word
);

   generate
      if (SAMPLE_W + SIDE_W > WORD_W) begin : g_bad_fit
         $error("sample plus status bits exceed the word");
      end
      if (2 * HALF_W != WORD_W) begin : g_bad_half
         $error("two halves must fill the word");
      end
      if (HALF_W > SAMPLE_W) begin : g_bad_trunc
         $error("packed half wider than sample");
      end
   endgenerate

   side_t             side_raw;
   side_t             side_msk;
   logic [WORD_W-1:0] lay_word;
   logic              pack_mode;
   logic              left_sel;
   logic              fire;
   logic [WORD_W-1:0] pair_word;

   assign pack_mode = (cfg_fmt == FMT_PACK);
   assign left_sel  = (cfg_fmt == FMT_LEFT);
   assign side_raw  = '{perr: in_perr, v: in_v, u: in_u, c: in_c, pre: in_pre};

   spdif_side_mask i_mask (
      .side_in  (side_raw),
      .mask_par (cfg_mask_par),
      .mask_val (cfg_mask_val),
      .mask_cu  (cfg_mask_cu),
      .mask_pre (cfg_mask_pre),
      .side_out (side_msk)
   );

   spdif_word_layout #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) i_layout (
      .sample   (in_sample),
      .side     (side_msk),
      .left_sel (left_sel),
      .word     (lay_word)
   );

   spdif_pair_packer #(.SAMPLE_W(SAMPLE_W), .HALF_W(HALF_W)) i_packer (
      .clk        (clk),
      .rst_n      (rst_n),
      .pack_mode  (pack_mode),
      .take       (in_valid & pack_mode),
      .chan_order (cfg_chan_order),
      .pre        (in_pre),
      .sample     (in_sample),
      .fire       (fire),
      .pair_word  (pair_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else if (in_valid && pack_mode) begin
         out_valid <= fire;
         if (fire) out_word <= pair_word;
      end else if (in_valid) begin
         out_valid <= 1'b1;
         out_word  <= lay_word;
      end else begin
         out_valid <= 1'b0;
      end
   end

   AST_RIGHT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (cfg_fmt == FMT_RIGHT || cfg_fmt == FMT_RSVD))
      |=> (out_valid && out_word[SAMPLE_W-1:0] == $past(in_sample)))   // R1
      else $error("right layout sample misplaced");

   AST_LEFT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_fmt == FMT_LEFT)
      |=> (out_valid && out_word[WORD_W-1 -: SAMPLE_W] == $past(in_sample)))   // R2
      else $error("left layout sample misplaced");

   AST_MASK_PAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_mask_par && cfg_fmt == FMT_LEFT) |=> !out_word[0])   // R5
      else $error("masked parity bit visible");

   AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid)   // R12
      else $error("strobe without subframe");

endmodule

// File: tb/test_spdif_word_fmt.sv
module test_spdif_word_fmt;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [23:0] in_sample = '0;
   logic        in_perr = 1'b0, in_v = 1'b0, in_u = 1'b0, in_c = 1'b0;
   logic [1:0]  in_pre = 2'b00;
   logic [1:0]  cfg_fmt = 2'b00;
   logic        cfg_mask_par = 1'b0, cfg_mask_val = 1'b0;
   logic        cfg_mask_cu = 1'b0, cfg_mask_pre = 1'b0;
   logic        cfg_chan_order = 1'b0;
   logic        out_valid;
   logic [31:0] out_word;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   spdif_word_fmt i_spdif_word_fmt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
      .in_perr(in_perr), .in_v(in_v), .in_u(in_u), .in_c(in_c), .in_pre(in_pre),
      .cfg_fmt(cfg_fmt), .cfg_mask_par(cfg_mask_par), .cfg_mask_val(cfg_mask_val),
      .cfg_mask_cu(cfg_mask_cu), .cfg_mask_pre(cfg_mask_pre),
      .cfg_chan_order(cfg_chan_order), .out_valid(out_valid), .out_word(out_word)
   );

   typedef struct packed {
      logic [1:0]  fmt;
      logic [3:0]  msk;   // {par, val, cu, pre}
      logic [23:0] smp;
      logic [3:0]  sd;    // {perr, v, u, c}
      logic [1:0]  pre;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{2'b00, 4'b0000, 24'hABCDEF, 4'b1111, 2'b11, 32'h3FABCDEF},  // R1
      '{2'b00, 4'b0000, 24'h123456, 4'b1010, 2'b01, 32'h15123456},  // R1
      '{2'b01, 4'b0000, 24'hABCDEF, 4'b1111, 2'b10, 32'hABCDEF2F},  // R2
      '{2'b01, 4'b0000, 24'h000001, 4'b0101, 2'b11, 32'h0000013A},  // R2
      '{2'b11, 4'b0000, 24'h654321, 4'b1111, 2'b10, 32'h2F654321},  // R3
      '{2'b00, 4'b1000, 24'hFFFFFF, 4'b1111, 2'b11, 32'h3EFFFFFF},  // R5
      '{2'b00, 4'b0100, 24'hFFFFFF, 4'b1111, 2'b11, 32'h3DFFFFFF},  // R6
      '{2'b01, 4'b0010, 24'h000000, 4'b1111, 2'b11, 32'h00000033},  // R7
      '{2'b01, 4'b0001, 24'h000000, 4'b1111, 2'b11, 32'h0000000F},  // R8
      '{2'b00, 4'b1111, 24'hABCDEF, 4'b1111, 2'b11, 32'h00ABCDEF}   // R5 R6 R7 R8
   };

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // drive one subframe; returns at the negedge after the capturing posedge
   task automatic send(input logic [23:0] s, input logic [3:0] sd, input logic [1:0] p);
      @(negedge clk);
      in_sample = s;
      {in_perr, in_v, in_u, in_c} = sd;
      in_pre = p;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({31'd0, out_valid}, 32'd0, "R12 reset valid");
      chk(out_word, 32'd0, "R12 reset word");
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         cfg_fmt = TBL[i].fmt;
         {cfg_mask_par, cfg_mask_val, cfg_mask_cu, cfg_mask_pre} = TBL[i].msk;
         send(TBL[i].smp, TBL[i].sd, TBL[i].pre);
         chk({31'd0, out_valid}, 32'd1, "R12 strobe after layout vector");
         chk(out_word, TBL[i].exp, $sformatf("R1/R2/R3/R5-8 vector %0d", i));
      end
      @(negedge clk);
      chk({31'd0, out_valid}, 32'd0, "R12 strobe lasts one cycle");

      // packed, no stereo order; masks must not matter
      cfg_fmt = 2'b10;
      {cfg_mask_par, cfg_mask_val, cfg_mask_cu, cfg_mask_pre} = 4'b0000;
      cfg_chan_order = 1'b0;
      send(24'h111122, 4'b1111, 2'b10);
      chk({31'd0, out_valid}, 32'd0, "R4 no word on first half");
      send(24'h3333AA, 4'b1111, 2'b11);
      chk({31'd0, out_valid}, 32'd1, "R4 strobe on second half");
      chk(out_word, 32'h33331111, "R4 packed pair");

      // no order: channel B first still pairs
      send(24'hAAAA00, 4'b0000, 2'b11);
      chk({31'd0, out_valid}, 32'd0, "R10 unordered first half");
      send(24'hBBBB00, 4'b0000, 2'b10);
      chk(out_word, 32'hBBBBAAAA, "R10 unordered pair");

      // order set: stray B dropped
      cfg_chan_order = 1'b1;
      send(24'h777700, 4'b0000, 2'b11);
      chk({31'd0, out_valid}, 32'd0, "R9 stray B no word");
      send(24'h121200, 4'b0000, 2'b01);
      chk({31'd0, out_valid}, 32'd0, "R9 A after dropped B held");
      send(24'h343400, 4'b0000, 2'b11);
      chk({31'd0, out_valid}, 32'd1, "R9 pair strobe");
      chk(out_word, 32'h34341212, "R9 pair excludes dropped B");

      // order set: second A replaces held half
      send(24'h565600, 4'b0000, 2'b10);
      send(24'h787800, 4'b0000, 2'b10);
      chk({31'd0, out_valid}, 32'd0, "R10 replacing A no word");
      send(24'h9A9A00, 4'b0000, 2'b11);
      chk(out_word, 32'h9A9A7878, "R10 replaced half");

      // leaving packed mode drops the held half
      cfg_chan_order = 1'b0;
      send(24'hCDCD00, 4'b0000, 2'b10);
      @(negedge clk);
      cfg_fmt = 2'b00;
      send(24'h00BEEF, 4'b0000, 2'b10);
      chk(out_word, 32'h2000BEEF, "R11 unpacked word in between");
      cfg_fmt = 2'b10;
      send(24'h1F1F00, 4'b0000, 2'b10);
      chk({31'd0, out_valid}, 32'd0, "R11 fresh first half");
      send(24'h2E2E00, 4'b0000, 2'b11);
      chk(out_word, 32'h2E2E1F1F, "R11 pair after format change");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule